// File: doc/BRIEF.md
# Scaled Dot-Product Dequantizer with 8-bit Float Scales

This block turns the raw result of one block dot product into a normalized floating-point partial sum. It receives a sign and an unnormalized 12-bit fixed-point magnitude from the integer dot-product array. It also receives the two block scales, one for weights and one for activations. Each scale is an unsigned 7-bit float with a 4-bit exponent and a 3-bit mantissa. The block multiplies the two scale significands together, multiplies that product by the magnitude and adds the scale exponents. It then locates the leading one, shifts it out and packs a word of sign, 5-bit exponent and 19-bit mantissa.

The path is a two-stage pipeline. Stage one multiplies and stage two normalizes. It takes one result per clock, and a valid flag travels alongside the data. Results that are too small are flushed to zero. Results that are too large are clamped to the largest finite value. The scale that applies to the whole tensor and the accumulation across blocks are handled downstream.

Top module: `e4m3_scale_dequant`

## Requirements
- R1: A scale byte carries its exponent field in bits [6:3] and its mantissa field in bits [2:0]. When the exponent field is nonzero, the scale value is 2^(exp-7) × 1.man.
- R2: Bit j of `magIn` (j = 0..11) has weight 2^(j-2), so the magnitude is magIn/4.
- R3: A nonzero in-range result has the value (-1)^outSign × 2^(outExp-15) × 1.outMan. The 19-bit `outMan` holds every bit of the exact product below its leading one, left-justified and zero-padded, with no rounding.
- R4: A scale whose exponent field is 0 has the value 2^-6 × 0.man.
- R5: When `magIn` is 0, or either scale has the value 0, the output has sign, exponent and mantissa all zero.
- R6: When the exact result is below 2^-14 (biased exponent 0 or less), the output is all zero.
- R7: When the exact result is 2^16 or larger (biased exponent 31 or more), the output keeps its sign, with exponent 30 and a mantissa of all ones. An exponent field of 31 never appears.
- R8: Every nonzero result carries the `inSign` that entered with it.
- R9: `outValid` equals `inValid` from two clocks earlier. A new input is accepted on every clock.
- R10: While `outValid` is low, `outSign`, `outExp` and `outMan` keep their previous values.
- R11: While reset is held, `outValid`, `outSign`, `outExp` and `outMan` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input sample is valid this cycle |
| inSign | input | 1 | Sign of the dot-product result |
| scaleA | input | 7 | Activation block scale, exponent [6:3], mantissa [2:0] |
| scaleW | input | 7 | Weight block scale, exponent [6:3], mantissa [2:0] |
| magIn | input | 12 | Unnormalized magnitude, two fraction bits |
| outValid | output | 1 | Result valid, two cycles after its input |
| outSign | output | 1 | Result sign |
| outExp | output | 5 | Result exponent, bias 15 |
| outMan | output | 19 | Result mantissa, hidden one excluded |

## Verification
Clamping and sign passing can land in the same output cycle. So can a subnormal scale and the underflow flush. The bench provokes these pairings with scales at the extremes of their exponent range and with a negative sign, including the cases exactly at biased exponents 0, 1, 30 and 31. Separately, a normalization in stage two and a fresh multiply in stage one coincide whenever samples arrive back to back. The bench streams samples with and without gaps, and it compares every output cycle against a behavioural model that computes the exact product as an integer.

// File: rtl/dq_pkg.sv
package dq_pkg;

  // Strobes the control path hands to the datapath each cycle.
  typedef struct packed {
    logic mulLoad;   // capture the significand product
    logic normLoad;  // capture the normalized result
  } dqStrobe_t;

endpackage

// File: rtl/dq_scale_decode.sv
module dq_scale_decode #(
  parameter int EXP_W = 4,
  parameter int MAN_W = 3
) (
  input  logic [EXP_W+MAN_W-1:0] scaleIn,
  output logic [MAN_W:0]         sigOut,
  output logic [EXP_W-1:0]       effExp,
  output logic                   isZero
);

  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] manField;
  logic             isSub;

  assign expField = scaleIn[EXP_W+MAN_W-1:MAN_W];
  assign manField = scaleIn[MAN_W-1:0];
  assign isSub    = (expField == '0);

  // A subnormal scale has no hidden one and uses the minimum exponent.
  assign sigOut = {~isSub, manField};
  assign effExp = isSub ? EXP_W'(1) : expField;
  assign isZero = isSub && (manField == '0);

endmodule

// File: rtl/dq_lead_one.sv
module dq_lead_one #(
  parameter int W = 20,
  localparam int POS_W = $clog2(W)
) (
  input  logic [W-1:0]     vecIn,
  output logic [POS_W-1:0] posOut,
  output logic             found
);

  always_comb begin
    posOut = '0;
    found  = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vecIn[i]) begin
        posOut = POS_W'(i);
        found  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dq_ctrl.sv
module dq_ctrl
  import dq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output dqStrobe_t strobe,
  output logic      outValid
);

  logic stage1Valid;
  logic stage2Valid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      stage2Valid <= stage1Valid;
    end
  end

  assign strobe.mulLoad  = inValid;
  assign strobe.normLoad = stage1Valid;
  assign outValid        = stage2Valid;

endmodule

// File: rtl/dq_datapath.sv
module dq_datapath
  import dq_pkg::*;
#(
  parameter int SC_EXP_W  = 4,
  parameter int SC_MAN_W  = 3,
  parameter int MAG_W     = 12,
  parameter int MAG_FRAC  = 2,
  parameter int OUT_EXP_W = 5,
  parameter int OUT_MAN_W = 19
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dqStrobe_t                    strobe,
  input  logic                         inSign,
  input  logic [SC_EXP_W+SC_MAN_W-1:0] scaleA,
  input  logic [SC_EXP_W+SC_MAN_W-1:0] scaleW,
  input  logic [MAG_W-1:0]             magIn,
  output logic                         outSign,
  output logic [OUT_EXP_W-1:0]         outExp,
  output logic [OUT_MAN_W-1:0]         outMan
);

  localparam int SC_W       = SC_EXP_W + SC_MAN_W;
  localparam int SIG_W      = SC_MAN_W + 1;
  localparam int SIGP_W     = 2 * SIG_W;
  localparam int PROD_W     = SIGP_W + MAG_W;
  localparam int PROD_FRAC  = 2 * SC_MAN_W + MAG_FRAC;
  localparam int POS_W      = $clog2(PROD_W);
  localparam int SC_BIAS    = (1 << (SC_EXP_W - 1)) - 1;
  localparam int OUT_BIAS   = (1 << (OUT_EXP_W - 1)) - 1;
  localparam int EXP_ALL1   = (1 << OUT_EXP_W) - 1;
  localparam int EXP_OFF    = OUT_BIAS - 2 * SC_BIAS - PROD_FRAC;
  localparam int FRAC_BITS  = PROD_W - 1;
  localparam int MANT_PAD   = OUT_MAN_W - FRAC_BITS;
  localparam logic [POS_W-1:0] TOP_POS = POS_W'(PROD_W - 1);

  // ---------------- stage 1: decode and multiply ----------------
  logic [SC_W-1:0]     scaleVec [2];
  logic [SIG_W-1:0]    sigVec   [2];
  logic [SC_EXP_W-1:0] expVec   [2];
  logic [1:0]          zeroVec;

  assign scaleVec[0] = scaleA;
  assign scaleVec[1] = scaleW;

  for (genvar g = 0; g < 2; g++) begin : gen_dec
    dq_scale_decode #(
      .EXP_W(SC_EXP_W),
      .MAN_W(SC_MAN_W)
    ) u_dec (
      .scaleIn(scaleVec[g]),
      .sigOut (sigVec[g]),
      .effExp (expVec[g]),
      .isZero (zeroVec[g])
    );
  end

  logic [SIGP_W-1:0]   sigProd;
  logic [PROD_W-1:0]   fullProd;
  logic [SC_EXP_W:0]   expSum;
  logic                anyZero;

  assign sigProd  = SIGP_W'(sigVec[0]) * SIGP_W'(sigVec[1]);
  assign fullProd = PROD_W'(sigProd) * PROD_W'(magIn);
  assign expSum   = {1'b0, expVec[0]} + {1'b0, expVec[1]};
  assign anyZero  = (|zeroVec) || (magIn == '0);

  logic [PROD_W-1:0] prodQ;
  logic [SC_EXP_W:0] expSumQ;
  logic              signQ;
  logic              zeroQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodQ   <= '0;
      expSumQ <= '0;
      signQ   <= 1'b0;
      zeroQ   <= 1'b1;
    end else if (strobe.mulLoad) begin
      prodQ   <= fullProd;
      expSumQ <= expSum;
      signQ   <= inSign;
      zeroQ   <= anyZero;
    end
  end

  // ---------------- stage 2: normalize and pack ----------------
  logic [POS_W-1:0] leadPos;
  logic             leadFound;

  dq_lead_one #(
    .W(PROD_W)
  ) u_lead (
    .vecIn (prodQ),
    .posOut(leadPos),
    .found (leadFound)
  );

  logic [PROD_W-1:0]    shifted;
  logic [OUT_MAN_W-1:0] normMan;

  assign shifted = prodQ << (TOP_POS - leadPos);

  if (MANT_PAD == 0) begin : gen_man_exact
    assign normMan = shifted[FRAC_BITS-1:0];
  end else if (MANT_PAD > 0) begin : gen_man_pad
    assign normMan = {shifted[FRAC_BITS-1:0], MANT_PAD'(0)};
  end else begin : gen_man_trunc
    assign normMan = shifted[FRAC_BITS-1 -: OUT_MAN_W];
  end

  int                   fieldVal;
  logic                 nxtSign;
  logic [OUT_EXP_W-1:0] nxtExp;
  logic [OUT_MAN_W-1:0] nxtMan;

  always_comb begin
    fieldVal = int'(expSumQ) + int'(leadPos) + EXP_OFF;
    if (zeroQ || !leadFound || fieldVal <= 0) begin
      nxtSign = 1'b0;
      nxtExp  = '0;
      nxtMan  = '0;
    end else if (fieldVal >= EXP_ALL1) begin
      nxtSign = signQ;
      nxtExp  = OUT_EXP_W'(EXP_ALL1 - 1);
      nxtMan  = '1;
    end else begin
      nxtSign = signQ;
      nxtExp  = OUT_EXP_W'(fieldVal);
      nxtMan  = normMan;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outSign <= 1'b0;
      outExp  <= '0;
      outMan  <= '0;
    end else if (strobe.normLoad) begin
      outSign <= nxtSign;
      outExp  <= nxtExp;
      outMan  <= nxtMan;
    end
  end

endmodule

// File: rtl/e4m3_scale_dequant.sv
module e4m3_scale_dequant
  import dq_pkg::*;
#(
  parameter int SC_EXP_W  = 4,
  parameter int SC_MAN_W  = 3,
  parameter int MAG_W     = 12,
  parameter int MAG_FRAC  = 2,
  parameter int OUT_EXP_W = 5,
  parameter int OUT_MAN_W = 19
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  input  logic                         inSign,
  input  logic [SC_EXP_W+SC_MAN_W-1:0] scaleA,
  input  logic [SC_EXP_W+SC_MAN_W-1:0] scaleW,
  input  logic [MAG_W-1:0]             magIn,
  output logic                         outValid,
  output logic                         outSign,
  output logic [OUT_EXP_W-1:0]         outExp,
  output logic [OUT_MAN_W-1:0]         outMan
);

  dqStrobe_t strobe;

  dq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  dq_datapath #(
    .SC_EXP_W (SC_EXP_W),
    .SC_MAN_W (SC_MAN_W),
    .MAG_W    (MAG_W),
    .MAG_FRAC (MAG_FRAC),
    .OUT_EXP_W(OUT_EXP_W),
    .OUT_MAN_W(OUT_MAN_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .inSign (inSign),
    .scaleA (scaleA),
    .scaleW (scaleW),
    .magIn  (magIn),
    .outSign(outSign),
    .outExp (outExp),
    .outMan (outMan)
  );

endmodule

// File: rtl/dq_checker.sv
module dq_checker #(
  parameter int MAG_W     = 12,
  parameter int OUT_EXP_W = 5,
  parameter int OUT_MAN_W = 19
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic                 inSign,
  input logic [MAG_W-1:0]     magIn,
  input logic                 outValid,
  input logic                 outSign,
  input logic [OUT_EXP_W-1:0] outExp,
  input logic [OUT_MAN_W-1:0] outMan
);

  // Cycles since reset release, saturating, so $past never reaches before it.
  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  p_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> (outValid == $past(inValid, 2)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd1 && !outValid) |-> ($stable(outExp) && $stable(outMan) && $stable(outSign)));

  p_no_inf_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outExp != '1));

  p_flush_clean_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outExp == '0) |-> (outMan == '0 && !outSign));

  p_zero_mag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && $past(inValid, 2) && $past(magIn, 2) == '0)
      |-> (outExp == '0 && outMan == '0 && !outSign));

  p_sign_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && outValid && outExp != '0) |-> (outSign == $past(inSign, 2)));

endmodule

bind e4m3_scale_dequant dq_checker #(
  .MAG_W    (MAG_W),
  .OUT_EXP_W(OUT_EXP_W),
  .OUT_MAN_W(OUT_MAN_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inSign  (inSign),
  .magIn   (magIn),
  .outValid(outValid),
  .outSign (outSign),
  .outExp  (outExp),
  .outMan  (outMan)
);

// File: tb/e4m3_scale_dequant_tb.sv
module e4m3_scale_dequant_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic        inSign;
  logic [6:0]  scaleA;
  logic [6:0]  scaleW;
  logic [11:0] magIn;
  logic        outValid;
  logic        outSign;
  logic [4:0]  outExp;
  logic [18:0] outMan;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  e4m3_scale_dequant u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSign(inSign),
    .scaleA(scaleA), .scaleW(scaleW), .magIn(magIn),
    .outValid(outValid), .outSign(outSign), .outExp(outExp), .outMan(outMan)
  );

  typedef struct {
    bit        v;
    bit        s;
    bit [6:0]  a;
    bit [6:0]  w;
    bit [11:0] m;
    string     tag;
  } stim_t;

  stim_t pipeQ[$];

  bit        mV;
  bit        mS;
  bit [4:0]  mE;
  bit [18:0] mM;

  // Behavioural reference: exact integer product, value = p * 2^(ea+ew-14-8).
  function automatic void refCalc(input bit s, input bit [6:0] a, input bit [6:0] w,
                                  input bit [11:0] m, output bit os,
                                  output bit [4:0] oe, output bit [18:0] om);
    int ea, ew, sa, sw, p, lead, f;
    longint sh;
    ea = (a[6:3] == 0) ? 1 : int'(a[6:3]);
    ew = (w[6:3] == 0) ? 1 : int'(w[6:3]);
    sa = (a[6:3] == 0) ? int'(a[2:0]) : 8 + int'(a[2:0]);
    sw = (w[6:3] == 0) ? int'(w[2:0]) : 8 + int'(w[2:0]);
    p  = sa * sw * int'(m);
    os = 0; oe = 0; om = 0;
    if (p == 0) return;
    lead = 0;
    for (int i = 0; i < 31; i++) if (((p >> i) & 1) == 1) lead = i;
    f = ea + ew - 14 + 15 + lead - 8;
    if (f <= 0) return;
    os = s;
    if (f >= 31) begin
      oe = 5'd30;
      om = '1;
      return;
    end
    oe = 5'(f);
    sh = longint'(p) << (19 - lead);
    om = 19'(sh);
  endfunction

  task automatic compareOut(input string tag);
    checks++;
    if (outValid !== mV || outSign !== mS || outExp !== mE || outMan !== mM) begin
      fails++;
      $display("FAIL %s: got v=%b s=%b e=%0d m=%h, expected v=%b s=%b e=%0d m=%h",
               tag, outValid, outSign, outExp, outMan, mV, mS, mE, mM);
    end
  endtask

  task automatic step(input bit v, input bit s, input bit [6:0] a, input bit [6:0] w,
                      input bit [11:0] m, input string tag);
    stim_t old;
    stim_t cur;
    @(negedge clk);
    old = pipeQ.pop_front();
    mV = old.v;
    if (old.v) refCalc(old.s, old.a, old.w, old.m, mS, mE, mM);
    compareOut(old.v ? old.tag : "R10/R9");
    inValid = v; inSign = s; scaleA = a; scaleW = w; magIn = m;
    cur.v = v; cur.s = s; cur.a = a; cur.w = w; cur.m = m; cur.tag = tag;
    pipeQ.push_back(cur);
  endtask

  // Hand-computed absolute check of a registered result (R3 value 1.0).
  task automatic litCheck(input bit [4:0] e, input bit [18:0] m, input string tag);
    checks++;
    if (outExp !== e || outMan !== m) begin
      fails++;
      $display("FAIL %s: got e=%0d m=%h, expected e=%0d m=%h", tag, outExp, outMan, e, m);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, got hung, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    stim_t idle;
    rstN = 1'b0; inValid = 0; inSign = 0; scaleA = 0; scaleW = 0; magIn = 0;
    mV = 0; mS = 0; mE = 0; mM = 0;
    repeat (3) @(negedge clk);
    compareOut("R11");
    rstN = 1'b1;
    idle.v = 0; idle.s = 0; idle.a = 0; idle.w = 0; idle.m = 0; idle.tag = "R11";
    pipeQ.push_back(idle);
    pipeQ.push_back(idle);

    step(1, 0, 7'h38, 7'h38, 12'd4,   "R3");    // 1.0 x 1.0 x 1.0
    step(0, 0, 7'h00, 7'h00, 12'd0,   "R10");
    step(0, 1, 7'h7f, 7'h7f, 12'hfff, "R10");
    litCheck(5'd15, 19'd0, "R3");
    step(1, 0, 7'h38, 7'h38, 12'd1,   "R2");    // 0.25
    step(1, 0, 7'h38, 7'h38, 12'h800, "R2");    // 512
    step(1, 0, 7'h3d, 7'h4b, 12'h00a, "R1");    // mixed mantissas
    step(1, 1, 7'h45, 7'h2e, 12'h5a3, "R1");
    step(1, 0, 7'h01, 7'h38, 12'd4,   "R4");    // 2^-9
    step(1, 0, 7'h07, 7'h40, 12'h123, "R4");
    step(1, 1, 7'h00, 7'h55, 12'h3ff, "R5");    // zero scale
    step(1, 1, 7'h55, 7'h44, 12'h000, "R5");    // zero magnitude
    step(1, 0, 7'h01, 7'h01, 12'd1,   "R6");    // far below range
    step(1, 1, 7'h04, 7'h08, 12'd1,   "R6");    // exponent exactly 0
    step(1, 0, 7'h08, 7'h08, 12'd1,   "R6");    // exponent exactly 1, kept
    step(1, 1, 7'h7f, 7'h7f, 12'hfff, "R7");    // far above range, negative
    step(1, 0, 7'h78, 7'h78, 12'd4,   "R7");    // exponent exactly 31
    step(1, 1, 7'h78, 7'h78, 12'd3,   "R7");    // exponent exactly 30, kept
    step(1, 1, 7'h3a, 7'h41, 12'h7c1, "R8");
    step(1, 1, 7'h02, 7'h7f, 12'hfff, "R8");    // subnormal with saturating partner
    for (int i = 0; i < 8; i++)
      step(1, i[0], 7'(8'h30 + i), 7'(8'h41 + 3 * i), 12'(12'h101 * (i + 1)), "R9");
    step(0, 0, 7'h11, 7'h22, 12'h333, "R10");
    step(0, 0, 7'h00, 7'h00, 12'h000, "R10");

    for (int i = 0; i < 400; i++) begin
      bit v;
      v = ($urandom_range(0, 3) != 0);
      step(v, 1'($urandom), 7'($urandom), 7'($urandom), 12'($urandom),
           v ? "R3" : "R10");
    end

    repeat (3) step(0, 0, 7'h00, 7'h00, 12'h000, "R10");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule